// File: doc/BRIEF.md
# VBI Blanking Gate

The gate sits in a component video stream and decides, one sample at a time, whether content on lines of the vertical blanking interval reaches the output or is replaced with the blanking level. The decision depends on the line number carried with each sample, the selected standard (NTSC, PAL, 525p or 625p), an enable for VBI content and an enable for copy-generation data. Samples on active lines and the words of embedded timing codes always pass. The gate also carries the blanking bit decoded from the current line's timing code. In the standard-definition slave mode that takes its timing from the embedded codes, it clears that bit on lines where VBI content passes, so that downstream logic treats those lines as carrying content. The same enables govern master and slave timing.

Samples arrive on a valid/ready interface. The line number, component flag, timing-code flag and blanking bit travel as sideband fields of the same beat. A beat transfers when `in_valid` and `in_ready` are both high on a rising clock edge. The result is registered and is presented one clock later on `out_valid`/`out_data`/`out_blank_bit`. While `out_valid` is high and `out_ready` is low, the output holds and `in_ready` is low. The standard select and the enables are plain control levels that are sampled with each accepted beat. Line numbers count from 1 within each field (SD) or frame (progressive).

Top module: `vbi_blank_gate`

## Requirements
- R1: A sample whose line number lies beyond the blanking region passes unchanged. The region is lines 0–21 for NTSC (std 0), 0–23 for PAL (std 1), 0–42 for 525p (std 2) and 0–44 for 625p (std 3).
- R2: With VBI enabled, a region sample inside the pass window passes unchanged. The windows are NTSC 10–20, PAL 7–22, 525p 13–42 and 625p 6–43.
- R3: With VBI enabled, a region sample outside the pass window is replaced by the blanking level.
- R4: With VBI disabled, every region sample is replaced by the blanking level, except for the case covered by R5.
- R5: With copy-generation enabled, line 20 (NTSC) or line 23 (PAL) passes unchanged whatever the VBI enable. No line is exempt in this way for 525p or 625p.
- R6: The blanking level is 0x040 for luma samples (`in_chroma`=0) and 0x200 for chroma samples (`in_chroma`=1) at a 10-bit sample width. In general it is 2^(W-4) for luma and 2^(W-1) for chroma.
- R7: A sample flagged as a timing-code word (`in_tc`=1) passes unchanged on every line.
- R8: With `slave0_en`=1, VBI enabled and an SD standard, `out_blank_bit` is 0 on lines inside the pass window. In all other cases it equals `in_blank_bit`.
- R9: After reset `out_valid` is 0. An accepted beat appears at the output on the next clock edge, and beats leave in order.
- R10: While `out_valid`=1 and `out_ready`=0, the output beat (valid, data, blanking bit) holds unchanged.
- R11: `in_ready` is high exactly when the output register is empty or is being drained, so full throughput is sustained without bubbles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| std_sel | input | 2 | Standard: 0 NTSC, 1 PAL, 2 525p, 3 625p |
| vbi_en | input | 1 | Allow VBI content inside the pass window |
| cgms_en | input | 1 | Let the copy-generation line through |
| slave0_en | input | 1 | SD slave timing from embedded codes; enables blanking-bit rewrite |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Gate can accept a beat |
| in_data | input | DATA_W | Input sample |
| in_chroma | input | 1 | Sample is chroma (1) or luma (0) |
| in_tc | input | 1 | Sample is a timing-code word |
| in_line | input | LINE_W | Line number of the sample |
| in_blank_bit | input | 1 | Blanking bit from the line's timing code |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_data | output | DATA_W | Gated sample |
| out_blank_bit | output | 1 | Blanking bit, possibly cleared |

## Verification
The bench builds the gate with DATA_W=10 and LINE_W=7. The 10-bit width makes the blanking levels the familiar 0x040 and 0x200. The 7-bit line number lets the sweep cover all 128 line values, so every window edge, every region end and the line just past it are hit for each standard. Every combination of the two enables, the slave flag, the component flag, the timing-code flag and the incoming blanking bit is applied on each of those lines. Pseudo-random gaps on both valid and ready exercise the stall and hold behaviour throughout the sweep.

// File: rtl/vbi_gate_pkg.sv
package vbi_gate_pkg;

  typedef enum logic [1:0] {
    STD_NTSC = 2'd0,
    STD_PAL  = 2'd1,
    STD_525P = 2'd2,
    STD_625P = 2'd3
  } vid_std_e;

  // First line number guaranteed to be outside every blanking region
  localparam int unsigned ACTIVE_FLOOR = 45;

  function automatic logic std_is_sd(vid_std_e s);
    return (s == STD_NTSC) || (s == STD_PAL);
  endfunction

  // Last line of the blanking region (region starts at line 0)
  function automatic int unsigned region_end(vid_std_e s);
    case (s)
      STD_NTSC: return 21;
      STD_PAL:  return 23;
      STD_525P: return 42;
      default:  return 44;
    endcase
  endfunction

  function automatic int unsigned win_lo(vid_std_e s);
    case (s)
      STD_NTSC: return 10;
      STD_PAL:  return 7;
      STD_525P: return 13;
      default:  return 6;
    endcase
  endfunction

  function automatic int unsigned win_hi(vid_std_e s);
    case (s)
      STD_NTSC: return 20;
      STD_PAL:  return 22;
      STD_525P: return 42;
      default:  return 43;
    endcase
  endfunction

  // Copy-generation line; only meaningful for SD standards
  function automatic int unsigned copy_line(vid_std_e s);
    case (s)
      STD_NTSC: return 20;
      STD_PAL:  return 23;
      default:  return 0;
    endcase
  endfunction

endpackage

// File: rtl/vbi_line_decide.sv
module vbi_line_decide
  import vbi_gate_pkg::*;
#(
  parameter int LINE_W = 11
) (
  input  logic [1:0]        std_sel,
  input  logic              vbi_en,
  input  logic              cgms_en,
  input  logic              slave0_en,
  input  logic [LINE_W-1:0] line,
  input  logic              tc_word,
  input  logic              bbit_in,
  output logic              blank_req,
  output logic              bbit_out
);

  vid_std_e    std;
  logic [31:0] ln;
  logic        in_region;
  logic        in_window;
  logic        copy_hit;
  logic        sd;

  always_comb begin
    std       = vid_std_e'(std_sel);
    ln        = 32'(line);
    sd        = std_is_sd(std);
    in_region = ln <= region_end(std);
    in_window = (ln >= win_lo(std)) && (ln <= win_hi(std));
    copy_hit  = cgms_en && sd && (ln == copy_line(std));
    // Timing words and active lines always pass; the copy line bypasses a disabled VBI
    blank_req = !(tc_word || !in_region || copy_hit || (vbi_en && in_window));
    // Embedded-code slave mode: lines carrying VBI content are flagged as active
    bbit_out  = (slave0_en && vbi_en && sd && in_window) ? 1'b0 : bbit_in;
  end

endmodule

// File: rtl/vbi_level_mux.sv
module vbi_level_mux #(
  parameter int DATA_W = 10
) (
  input  logic [DATA_W-1:0] din,
  input  logic              is_chroma,
  input  logic              blank,
  output logic [DATA_W-1:0] dout
);

  localparam logic [DATA_W-1:0] LUMA_BLANK   = DATA_W'(1) << (DATA_W - 4);
  localparam logic [DATA_W-1:0] CHROMA_BLANK = DATA_W'(1) << (DATA_W - 1);

  logic [DATA_W-1:0] level;

  always_comb begin
    level = is_chroma ? CHROMA_BLANK : LUMA_BLANK;
    dout  = blank ? level : din;
  end

endmodule

// File: rtl/vbi_out_stage.sv
module vbi_out_stage #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [DATA_W-1:0] up_data,
  input  logic              up_bit,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [DATA_W-1:0] dn_data,
  output logic              dn_bit
);

  logic              full_q;
  logic [DATA_W-1:0] data_q;
  logic              bit_q;

  assign up_ready = !full_q || dn_ready;
  assign dn_valid = full_q;
  assign dn_data  = data_q;
  assign dn_bit   = bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
      bit_q  <= 1'b0;
    end else if (up_ready) begin
      full_q <= up_valid;
      if (up_valid) begin
        data_q <= up_data;
        bit_q  <= up_bit;
      end
    end
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data) && $stable(dn_bit)));

  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_ready) |=> dn_valid);

  p_drain_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && dn_ready && !up_valid) |=> !dn_valid);

endmodule

// File: rtl/vbi_blank_gate.sv
module vbi_blank_gate
  import vbi_gate_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        std_sel,
  input  logic              vbi_en,
  input  logic              cgms_en,
  input  logic              slave0_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_chroma,
  input  logic              in_tc,
  input  logic [LINE_W-1:0] in_line,
  input  logic              in_blank_bit,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_blank_bit
);

  logic              blank_req;
  logic              bbit_next;
  logic [DATA_W-1:0] gated;

  vbi_line_decide #(.LINE_W(LINE_W)) decide_i (
    .std_sel   (std_sel),
    .vbi_en    (vbi_en),
    .cgms_en   (cgms_en),
    .slave0_en (slave0_en),
    .line      (in_line),
    .tc_word   (in_tc),
    .bbit_in   (in_blank_bit),
    .blank_req (blank_req),
    .bbit_out  (bbit_next)
  );

  vbi_level_mux #(.DATA_W(DATA_W)) mux_i (
    .din       (in_data),
    .is_chroma (in_chroma),
    .blank     (blank_req),
    .dout      (gated)
  );

  vbi_out_stage #(.DATA_W(DATA_W)) stage_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (gated),
    .up_bit   (bbit_next),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (out_data),
    .dn_bit   (out_blank_bit)
  );

  logic in_fire;
  assign in_fire = in_valid && in_ready;

  p_tc_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && in_tc) |=> (out_data == $past(in_data)));

  p_active_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && (32'(in_line) >= ACTIVE_FLOOR)) |=> (out_data == $past(in_data)));

  p_bit_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && !slave0_en) |=> (out_blank_bit == $past(in_blank_bit)));

  p_bit_prog_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && std_sel[1]) |=> (out_blank_bit == $past(in_blank_bit)));

endmodule

// File: tb/vbi_blank_gate_tb_top.sv
`timescale 1ns/1ps
module vbi_blank_gate_tb_top;

  localparam int DW = 10;
  localparam int LW = 7;
  localparam int NV = 1 << (LW + 8);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    std_sel = '0;
  logic          vbi_en = 1'b0, cgms_en = 1'b0, slave0_en = 1'b0;
  logic          in_valid = 1'b0, in_chroma = 1'b0, in_tc = 1'b0, in_blank_bit = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic [LW-1:0] in_line = '0;
  logic          out_valid, out_blank_bit;
  logic          out_ready = 1'b0;
  logic [DW-1:0] out_data;

  always #2.5 clk = ~clk;

  vbi_blank_gate #(.DATA_W(DW), .LINE_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .std_sel(std_sel), .vbi_en(vbi_en),
    .cgms_en(cgms_en), .slave0_en(slave0_en), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_chroma(in_chroma),
    .in_tc(in_tc), .in_line(in_line), .in_blank_bit(in_blank_bit),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_blank_bit(out_blank_bit)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic          cap_in_fire = 1'b0, cap_out_fire = 1'b0, cap_stall = 1'b0;
  logic [DW-1:0] cap_data = '0;
  logic          cap_bit = 1'b0;

  always @(posedge clk) begin
    cap_in_fire  <= in_valid && in_ready;
    cap_out_fire <= out_valid && out_ready;
    cap_stall    <= out_valid && !out_ready;
    cap_data     <= out_data;
    cap_bit      <= out_blank_bit;
  end

  int    exp_d[$];
  int    exp_b[$];
  string exp_t[$];
  int    exp_i[$];

  function automatic int vec_data(int i);
    return ((i * 37) + 5) & 32'h3ff;
  endfunction

  // Reference model derived from the requirements
  task automatic model(input int i, output int ed, output int eb, output string tag);
    int ln, s, v, c, sl, ch, tc, bb, d;
    int rend, lo, hi, cl;
    bit sd, inwin;
    ln = i & 127; s = (i >> 7) & 3; v = (i >> 9) & 1; c = (i >> 10) & 1;
    sl = (i >> 11) & 1; ch = (i >> 12) & 1; tc = (i >> 13) & 1; bb = (i >> 14) & 1;
    d  = vec_data(i);
    case (s)
      0: begin rend = 21; lo = 10; hi = 20; cl = 20; end
      1: begin rend = 23; lo = 7;  hi = 22; cl = 23; end
      2: begin rend = 42; lo = 13; hi = 42; cl = -1; end
      default: begin rend = 44; lo = 6; hi = 43; cl = -1; end
    endcase
    sd    = (s < 2);
    inwin = (ln >= lo) && (ln <= hi);
    if (tc == 1) begin ed = d; tag = "R7"; end
    else if (ln > rend) begin ed = d; tag = "R1"; end
    else if (c == 1 && sd && ln == cl) begin ed = d; tag = "R5"; end
    else if (v == 1 && inwin) begin ed = d; tag = "R2"; end
    else begin
      ed  = (ch == 1) ? 512 : 64;
      tag = (v == 1) ? "R3/R6" : "R4/R6";
    end
    eb = (sl == 1 && v == 1 && sd && inwin) ? 0 : bb;
  endtask

  task automatic drive_vec(int i);
    in_line      = LW'(i & 127);
    std_sel      = 2'((i >> 7) & 3);
    vbi_en       = 1'((i >> 9) & 1);
    cgms_en      = 1'((i >> 10) & 1);
    slave0_en    = 1'((i >> 11) & 1);
    in_chroma    = 1'((i >> 12) & 1);
    in_tc        = 1'((i >> 13) & 1);
    in_blank_bit = 1'((i >> 14) & 1);
    in_data      = DW'(vec_data(i));
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, %0d beats outstanding, got not-finished exp finished", exp_d.size());
      summary();
      $finish;
    end
  end

  initial begin : main
    int idx;
    logic [15:0] lfsr;
    idx  = 0;
    lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++; $display("FAIL R9 reset out_valid got %b exp 0", out_valid);
    end
    checks++;
    if (in_ready !== 1'b1) begin
      fails++; $display("FAIL R11 reset in_ready got %b exp 1", in_ready);
    end
    rst_n = 1'b1;
    @(negedge clk);
    while (!(idx == NV && exp_d.size() == 0 && !out_valid)) begin
      @(negedge clk);
      if (cap_stall) begin
        checks++;
        if (!out_valid || out_data !== cap_data || out_blank_bit !== cap_bit) begin
          fails++;
          $display("FAIL R10 hold got v=%b d=%h b=%b exp v=1 d=%h b=%b",
                   out_valid, out_data, out_blank_bit, cap_data, cap_bit);
        end
      end
      if (cap_out_fire) begin
        int ed, eb, vi;
        string tg;
        checks++;
        if (exp_d.size() == 0) begin
          fails++; $display("FAIL R9 unexpected output beat got d=%h exp none", cap_data);
        end else begin
          ed = exp_d.pop_front(); eb = exp_b.pop_front();
          tg = exp_t.pop_front(); vi = exp_i.pop_front();
          if (int'(cap_data) != ed) begin
            fails++;
            $display("FAIL %s vec %0d line=%0d std=%0d data got %h exp %h",
                     tg, vi, vi & 127, (vi >> 7) & 3, cap_data, ed);
          end
          checks++;
          if (int'(cap_bit) != eb) begin
            fails++;
            $display("FAIL R8 vec %0d line=%0d std=%0d blank bit got %b exp %0d",
                     vi, vi & 127, (vi >> 7) & 3, cap_bit, eb);
          end
        end
      end
      if (cap_in_fire) begin
        int ed, eb;
        string tg;
        model(idx, ed, eb, tg);
        exp_d.push_back(ed); exp_b.push_back(eb);
        exp_t.push_back(tg); exp_i.push_back(idx);
        idx++;
      end
      // R11: ready follows the output register state and downstream ready
      checks++;
      if (in_ready !== (!out_valid || out_ready)) begin
        fails++;
        $display("FAIL R11 in_ready got %b exp %b", in_ready, (!out_valid || out_ready));
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = (lfsr[1:0] != 2'b00);
      if (idx < NV) begin
        drive_vec(idx);
        in_valid = (lfsr[4:3] != 2'b00);
      end else begin
        in_valid = 1'b0;
      end
    end
    done = 1'b1;
    summary();
    $finish;
  end

endmodule